// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches the live calendar fields of a time-of-day counter (seconds, minutes, hours with a PM marker, weekday, day of month, month and a two-digit year, all in BCD) and compares them with a set of alarm bytes held in host-writable registers. Each alarm byte carries its own enable bit. A field whose enable is clear does not take part in the comparison. This lets software arm an alarm on any subset of the fields, for example "every minute at second 30" or "every day at 07:15".

The comparison is evaluated only on the counter's once-per-second update strobe. A status flag is set when the combined match first becomes true. A match that stays true over several updates sets the flag only once. The host clears the flag by writing zero to it. An interrupt line is the flag gated by an interrupt-enable bit. Register access uses plain write and read strobes with a select code. Reads are combinational.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset every alarm byte, the year enable, the interrupt enable and the alarm flag read as zero, and `alarm_irq` is low.
- R2: Writes go to the register picked by `wr_sel`. The select codes are: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year value, 7 year enable, 8 control, 9 status. Reads through `rd_sel` use the same codes. Seconds, minutes and hours keep all 8 bits. Weekday keeps bits 7 and 2:0. Day keeps bits 7 and 5:0. Month keeps bits 7 and 4:0. The year value keeps all 8 bits. The year enable keeps only bit 7. Control keeps only bit 0. Unused codes read zero.
- R3: For the codes 0 to 5, bit 7 of the alarm byte enables that field. An enabled field matches when its low bits equal the calendar input of the same width. A disabled field always counts as matched. The hour comparison covers bit 6 (PM) together with the BCD hour in bits 5:0.
- R4: The year field matches when the year value equals `cur_year`. It takes part only while bit 7 of the year enable register is 1.
- R5: When no field is enabled, the alarm flag is never set.
- R6: On a cycle with `sec_tick` high, the flag is set if every field matches and the match was false at the previous tick (or no tick has happened since reset). Without a tick the flag keeps its value, apart from the clear in R7.
- R7: Writing the status register with bit 0 at 0 clears the flag. Writing it with bit 0 at 1 has no effect. If a set and a clear fall in the same cycle, the set wins. Status bit 0 reads back the flag.
- R8: `alarm_irq` equals the alarm flag ANDed with control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle strobe at each seconds update of the counter |
| cur_sec | input | 7 | Live BCD seconds |
| cur_min | input | 7 | Live BCD minutes |
| cur_hour | input | 7 | Live hour: bit 6 PM, bits 5:0 BCD hour |
| cur_wday | input | 3 | Live weekday |
| cur_mday | input | 6 | Live BCD day of month |
| cur_mon | input | 5 | Live BCD month |
| cur_year | input | 8 | Live BCD year |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 4 | Register select for reads |
| rd_data | output | 8 | Read data, combinational |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
If the remembered previous-tick match is wrong, the effect appears at the very next matching tick. The flag is then either set twice within one match episode or missed at the start of a new one. The status read and `alarm_irq` show this in the cycle after that tick. A wrong stored enable or a wrong field mask shows up at once in the readback value. It also shows up as a wrong flag at the first tick whose calendar value differs only in that field. The random phase biases each calendar field toward the programmed alarm value, so that partial matches, full matches and persistent matches all occur.

// File: rtl/cal_alarm_match.sv
module cal_alarm_match (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [6:0] cur_sec,
  input  logic [6:0] cur_min,
  input  logic [6:0] cur_hour,
  input  logic [2:0] cur_wday,
  input  logic [5:0] cur_mday,
  input  logic [4:0] cur_mon,
  input  logic [7:0] cur_year,
  input  logic       wr_en,
  input  logic [3:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [3:0] rd_sel,
  output logic [7:0] rd_data,
  output logic       alarm_irq
);

  localparam logic [3:0] SEL_SEC  = 4'd0;
  localparam logic [3:0] SEL_MIN  = 4'd1;
  localparam logic [3:0] SEL_HOUR = 4'd2;
  localparam logic [3:0] SEL_WDAY = 4'd3;
  localparam logic [3:0] SEL_MDAY = 4'd4;
  localparam logic [3:0] SEL_MON  = 4'd5;
  localparam logic [3:0] SEL_YVAL = 4'd6;
  localparam logic [3:0] SEL_YEN  = 4'd7;
  localparam logic [3:0] SEL_CTRL = 4'd8;
  localparam logic [3:0] SEL_STAT = 4'd9;

  logic [7:0] al_sec, al_min, al_hour, al_wday, al_mday, al_mon, al_year;
  logic       yr_en, aie, flag, prev_hit;
  logic       m_sec, m_min, m_hour, m_wday, m_mday, m_mon, m_year;
  logic       any_en, hit, stat_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_sec  <= '0;
      al_min  <= '0;
      al_hour <= '0;
      al_wday <= '0;
      al_mday <= '0;
      al_mon  <= '0;
      al_year <= '0;
      yr_en   <= 1'b0;
      aie     <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_SEC:  al_sec  <= wr_data;
        SEL_MIN:  al_min  <= wr_data;
        SEL_HOUR: al_hour <= wr_data;
        SEL_WDAY: al_wday <= {wr_data[7], 4'b0, wr_data[2:0]};
        SEL_MDAY: al_mday <= {wr_data[7], 1'b0, wr_data[5:0]};
        SEL_MON:  al_mon  <= {wr_data[7], 2'b0, wr_data[4:0]};
        SEL_YVAL: al_year <= wr_data;
        SEL_YEN:  yr_en   <= wr_data[7];
        SEL_CTRL: aie     <= wr_data[0];
        default: ;
      endcase
    end
  end

  assign m_sec  = !al_sec[7]  || (al_sec[6:0]  == cur_sec);
  assign m_min  = !al_min[7]  || (al_min[6:0]  == cur_min);
  assign m_hour = !al_hour[7] || (al_hour[6:0] == cur_hour);
  assign m_wday = !al_wday[7] || (al_wday[2:0] == cur_wday);
  assign m_mday = !al_mday[7] || (al_mday[5:0] == cur_mday);
  assign m_mon  = !al_mon[7]  || (al_mon[4:0]  == cur_mon);
  assign m_year = !yr_en      || (al_year      == cur_year);

  assign any_en = al_sec[7] | al_min[7] | al_hour[7] | al_wday[7] |
                  al_mday[7] | al_mon[7] | yr_en;
  assign hit    = any_en & m_sec & m_min & m_hour & m_wday & m_mday & m_mon & m_year;
  assign stat_clr = wr_en && (wr_sel == SEL_STAT) && !wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      prev_hit <= 1'b0;
    end else begin
      if (sec_tick) prev_hit <= hit;
      if (sec_tick && hit && !prev_hit) flag <= 1'b1;
      else if (stat_clr)                flag <= 1'b0;
    end
  end

  assign alarm_irq = flag & aie;

  always_comb begin
    case (rd_sel)
      SEL_SEC:  rd_data = al_sec;
      SEL_MIN:  rd_data = al_min;
      SEL_HOUR: rd_data = al_hour;
      SEL_WDAY: rd_data = al_wday;
      SEL_MDAY: rd_data = al_mday;
      SEL_MON:  rd_data = al_mon;
      SEL_YVAL: rd_data = al_year;
      SEL_YEN:  rd_data = {yr_en, 7'b0};
      SEL_CTRL: rd_data = {7'b0, aie};
      SEL_STAT: rd_data = {7'b0, flag};
      default:  rd_data = 8'h00;
    endcase
  end

  // R6
  flag_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(sec_tick) && !$past(prev_hit)));

  // R5
  no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(any_en));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_STAT && !wr_data[0] && !sec_tick) |=> !flag);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !(wr_en && wr_sel == SEL_STAT)) |=> $stable(flag));

endmodule

// File: tb/sim_cal_alarm_match.sv
module sim_cal_alarm_match;
  logic       clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [3:0] wr_sel = '0, rd_sel = '0;
  logic [7:0] rd_data;
  logic       alarm_irq;
  logic [7:0] c [0:6];

  int checks = 0, failures = 0;
  logic [7:0] mal [0:6];
  logic mflag = 1'b0, mprev = 1'b0, maie = 1'b0, myen = 1'b0;

  always #4 clk = ~clk;

  cal_alarm_match u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .cur_sec(c[0][6:0]), .cur_min(c[1][6:0]), .cur_hour(c[2][6:0]),
    .cur_wday(c[3][2:0]), .cur_mday(c[4][5:0]), .cur_mon(c[5][4:0]),
    .cur_year(c[6]), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .alarm_irq(alarm_irq));

  function automatic logic [7:0] mask_of(input int s);
    case (s)
      3: return 8'h87;
      4: return 8'hBF;
      5: return 8'h9F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic model_hit();
    logic any, all;
    any = myen;
    all = !myen || (mal[6] == c[6]);
    for (int i = 0; i < 6; i++) begin
      logic [7:0] vm;
      vm = mask_of(i) & 8'h7F;
      any = any | mal[i][7];
      all = all && (!mal[i][7] || ((mal[i] & vm) == (c[i] & vm)));
    end
    return any && all;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input int s, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_sel = 4'(s);
    #1 check(rd_data, exp, tag);
  endtask

  task automatic state_chk(input string tag);
    rd_chk(9, {7'b0, mflag}, tag);
    check({7'b0, alarm_irq}, {7'b0, mflag & maie}, "R8 irq");
  endtask

  task automatic wr(input int s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'(s); wr_data = d;
    @(posedge clk);
    if (s <= 6) mal[s] = d & mask_of(s);
    else if (s == 7) myen = d[7];
    else if (s == 8) maie = d[0];
    else if (s == 9 && !d[0]) mflag = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input logic [7:0] v [0:6], input logic clr);
    logic h;
    @(negedge clk);
    for (int i = 0; i < 7; i++) c[i] = v[i];
    sec_tick = 1'b1;
    if (clr) begin wr_en = 1'b1; wr_sel = 4'd9; wr_data = 8'h00; end
    @(posedge clk);
    h = model_hit();
    if (h && !mprev) mflag = 1'b1;
    else if (clr) mflag = 1'b0;
    mprev = h;
    @(negedge clk);
    sec_tick = 1'b0; wr_en = 1'b0;
  endtask

  logic [7:0] v [0:6];

  task automatic set_v(input logic [7:0] s, input logic [7:0] h, input logic [7:0] y);
    v[0] = s; v[1] = 8'h10; v[2] = h; v[3] = 8'h02; v[4] = 8'h15; v[5] = 8'h06; v[6] = y;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED1234);
    for (int i = 0; i < 7; i++) begin c[i] = '0; mal[i] = '0; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    for (int s = 0; s < 10; s++) rd_chk(s, 8'h00, "R1 reset value");
    check({7'b0, alarm_irq}, 8'h00, "R1 irq after reset");

    wr(3, 8'hFF); rd_chk(3, 8'h87, "R2 weekday mask");
    wr(4, 8'hFF); rd_chk(4, 8'hBF, "R2 day mask");
    wr(5, 8'hFF); rd_chk(5, 8'h9F, "R2 month mask");
    wr(7, 8'hFF); rd_chk(7, 8'h80, "R2 year enable mask");
    wr(8, 8'hFF); rd_chk(8, 8'h01, "R2 control mask");
    wr(2, 8'hD1); rd_chk(2, 8'hD1, "R2 hour byte");
    rd_chk(12, 8'h00, "R2 unused code");
    for (int s = 0; s < 9; s++) wr(s, 8'h00);

    set_v(8'h25, 8'h11, 8'h24);
    tick(v, 1'b0); state_chk("R5 nothing enabled");

    wr(0, 8'hA5);
    tick(v, 1'b0); state_chk("R3 seconds match");
    wr(8, 8'h01); state_chk("R8 irq enabled");
    wr(9, 8'h01); state_chk("R7 write one ignored");
    wr(9, 8'h00); state_chk("R7 clear");
    tick(v, 1'b0); state_chk("R6 persistent match no reset");
    set_v(8'h26, 8'h11, 8'h24); tick(v, 1'b0); state_chk("R6 mismatch");
    set_v(8'h25, 8'h11, 8'h24); tick(v, 1'b0); state_chk("R6 new match");

    wr(9, 8'h00);
    wr(2, 8'hD1);
    tick(v, 1'b0); state_chk("R3 hour PM mismatch");
    set_v(8'h25, 8'h51, 8'h24); tick(v, 1'b0); state_chk("R3 hour PM match");

    wr(9, 8'h00); wr(0, 8'h00); wr(2, 8'h00); wr(6, 8'h24);
    tick(v, 1'b0); state_chk("R4 year disabled");
    wr(7, 8'h80);
    set_v(8'h25, 8'h51, 8'h23); tick(v, 1'b0); state_chk("R4 year mismatch");
    set_v(8'h25, 8'h51, 8'h24); tick(v, 1'b0); state_chk("R4 year match");
    wr(9, 8'h00);
    set_v(8'h25, 8'h51, 8'h23); tick(v, 1'b0);
    set_v(8'h25, 8'h51, 8'h24); tick(v, 1'b1); state_chk("R7 set wins over clear");
    set_v(8'h25, 8'h51, 8'h23); tick(v, 1'b1); state_chk("R7 clear with tick");

    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 3) begin
        int s;
        logic [7:0] d;
        s = $urandom_range(0, 7);
        d = 8'($urandom);
        d[7] = ($urandom_range(0, 3) == 0);
        wr(s, d);
        if (s <= 6) rd_chk(s, d & mask_of(s), "R2 random readback");
      end else if (op == 3) begin
        wr(9, 8'($urandom)); state_chk("R7 random status write");
      end else if (op == 4) begin
        wr(8, 8'($urandom)); state_chk("R8 random control");
      end else begin
        for (int i = 0; i < 7; i++)
          v[i] = ($urandom_range(0, 3) != 0) ? mal[i] : 8'($urandom);
        tick(v, ($urandom_range(0, 5) == 0));
        state_chk("R6 random tick");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule